// File: doc/BRIEF.md
# Transfer Check-Key Generator and Checker

This block produces and verifies the small check keys that accompany every word moved between memory and the processing units. On the generating side it takes a 24-bit data word and a 15-bit address and returns, one cycle later, three odd-parity bits for the word, a modulo-3 residue for the address, and a modulo-7 residue for the word read as a six-digit packed decimal number. It also flags any decimal digit in that word that is not a valid decimal digit.

On the checking side a transfer is presented with its kind (data, address, decimal or none), its word and the key that came with it. The checker recomputes the expected key and records a mismatch. Separately, the address the memory actually selected is compared with the address that was requested. Every mismatch sets a sticky error flag that stays set until the clear input is asserted. A per-transfer done/fail pulse pair reports the result of each key check individually.

Top module: `xfer_key_unit`

## Requirements
- R1: One cycle after `gen_valid` is high, `gen_out_valid` is high and `gen_pkey` holds odd-parity bits for `gen_data`. Bit 0 covers bits 11:0, bit 1 covers bits 23:12 and bit 2 covers all 24 bits, so each covered field plus its key bit has an odd count of ones. The key outputs hold their value while `gen_valid` is low.
- R2: With the timing of R1, `gen_akey` equals `gen_addr` modulo 3. The value 3 is never produced.
- R3: With the timing of R1, `gen_data` is read as six 4-bit decimal digits, with bits 23:20 the most significant digit. `gen_bkey` is the decimal value modulo 7 (0 to 6, never 7), and `gen_bcd_bad` is high when any digit is above 9.
- R4: A transfer of kind 0 (data) whose `chk_key` differs in any bit from the odd-parity key of `chk_word` sets `err_par`. A zero word with a zero key is therefore an error.
- R5: A transfer of kind 1 (address) compares `chk_key[1:0]` with `chk_word[14:0]` modulo 3 and sets `err_akey` on a difference. A received key of 3 is always an error. `chk_key[2]` and `chk_word[23:15]` are ignored.
- R6: A transfer of kind 2 (decimal) sets `err_bkey` when `chk_key` differs from the modulo-7 residue defined in R3, and a received key of 7 is always an error. Independently, it sets `err_digit` when any digit is above 9.
- R7: A transfer of kind 3 performs no check. It sets no flag and its `chk_fail` is low.
- R8: When `sel_valid` is high and `sel_addr` differs from `req_addr`, `err_sel` is set one cycle later.
- R9: `chk_done` is high exactly one cycle after `chk_valid`. In that same cycle `chk_fail` is high if the transfer failed any key or digit check (R4 to R6).
- R10: Error flags are set one cycle after the failing input and stay set until `clr_err` is sampled high. When a new error arrives in the same cycle as the clear, the flag stays set.
- R11: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_err | input | 1 | Clears the sticky error flags |
| gen_valid | input | 1 | Generator inputs are valid |
| gen_data | input | 24 | Word to be keyed |
| gen_addr | input | 15 | Address to be keyed |
| gen_out_valid | output | 1 | Generator keys updated in the previous cycle |
| gen_pkey | output | 3 | Parity key of the word |
| gen_akey | output | 2 | Modulo-3 key of the address |
| gen_bkey | output | 3 | Modulo-7 key of the decimal word |
| gen_bcd_bad | output | 1 | Word holds a digit above 9 |
| chk_valid | input | 1 | A transfer is presented for checking |
| chk_kind | input | 2 | 0 data, 1 address, 2 decimal, 3 none |
| chk_word | input | 24 | Received word |
| chk_key | input | 3 | Received key |
| sel_valid | input | 1 | Address compare is valid |
| req_addr | input | 15 | Requested address |
| sel_addr | input | 15 | Address actually selected |
| chk_done | output | 1 | Result of a check is available |
| chk_fail | output | 1 | That check failed |
| err_par | output | 1 | Sticky data parity error |
| err_akey | output | 1 | Sticky address residue error |
| err_bkey | output | 1 | Sticky decimal residue error |
| err_digit | output | 1 | Sticky invalid-digit error |
| err_sel | output | 1 | Sticky selected-address mismatch |

## Verification
A wrong key computation shows up on the generator outputs or on a spurious or missing `chk_fail` in the cycle right after the input. The reference model compares both on every clock. A flag register that drops early or never clears is different: it shows only as a sticky output that disagrees with the model in some later cycle. The bench therefore interleaves clears with error bursts, including clears that coincide with a new error, and keeps comparing across long stretches without a clear.

// File: rtl/xk_pkg.sv
package xk_pkg;
  localparam int DATA_W  = 24;
  localparam int HALF_W  = DATA_W / 2;
  localparam int ADDR_W  = 15;
  localparam int DIGIT_W = 4;
  localparam int DIGITS  = DATA_W / DIGIT_W;

  localparam int FLG_PAR   = 0;
  localparam int FLG_AKEY  = 1;
  localparam int FLG_BKEY  = 2;
  localparam int FLG_DIGIT = 3;
  localparam int FLG_SEL   = 4;
  localparam int NUM_FLAGS = 5;
  localparam int NUM_KEYF  = 4;  // flags that come from key checks

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_BCD  = 2'd2,
    KIND_NONE = 2'd3
  } xk_kind_e;

  // odd parity: key bit makes the covered ones-count odd
  function automatic logic [2:0] par_key(input logic [DATA_W-1:0] w);
    logic [2:0] k;
    k[0] = ~^w[HALF_W-1:0];
    k[1] = ~^w[DATA_W-1:HALF_W];
    k[2] = ~^w;
    return k;
  endfunction

  // binary residue modulo 3, folded from the top bit down
  function automatic logic [1:0] addr_res3(input logic [ADDR_W-1:0] a);
    int acc;
    acc = 0;
    for (int i = ADDR_W - 1; i >= 0; i--)
      acc = (acc * 2 + int'(a[i])) % 3;
    return 2'(acc);
  endfunction

  // decimal residue modulo 7, folded digit by digit (10 = 3 mod 7)
  function automatic logic [2:0] bcd_res7(input logic [DATA_W-1:0] w);
    int acc;
    acc = 0;
    for (int d = DIGITS - 1; d >= 0; d--)
      acc = (acc * 3 + int'(w[d*DIGIT_W +: DIGIT_W])) % 7;
    return 3'(acc);
  endfunction

  function automatic logic bcd_bad(input logic [DATA_W-1:0] w);
    logic bad;
    bad = 1'b0;
    for (int d = 0; d < DIGITS; d++)
      if (w[d*DIGIT_W +: DIGIT_W] > 4'd9) bad = 1'b1;
    return bad;
  endfunction
endpackage

// File: rtl/xk_gen.sv
module xk_gen
  import xk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic [2:0]        out_pkey,
  output logic [1:0]        out_akey,
  output logic [2:0]        out_bkey,
  output logic              out_bad
);
  logic [2:0] pkey_d;
  logic [1:0] akey_d;
  logic [2:0] bkey_d;
  logic       bad_d;

  always_comb begin
    pkey_d = par_key(in_data);
    akey_d = addr_res3(in_addr);
    bkey_d = bcd_res7(in_data);
    bad_d  = bcd_bad(in_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pkey  <= '0;
      out_akey  <= '0;
      out_bkey  <= '0;
      out_bad   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pkey <= pkey_d;
        out_akey <= akey_d;
        out_bkey <= bkey_d;
        out_bad  <= bad_d;
      end
    end
  end

  assert_gen_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_gen_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_pkey) && $stable(out_akey) && !out_valid);
  assert_akey_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_akey != 2'd3);
  assert_bkey_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_bkey != 3'd7);
endmodule

// File: rtl/xk_chk.sv
module xk_chk
  import xk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chk_valid,
  input  logic [1:0]           chk_kind,
  input  logic [DATA_W-1:0]    chk_word,
  input  logic [2:0]           chk_key,
  input  logic                 sel_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [ADDR_W-1:0]    sel_addr,
  output logic [NUM_FLAGS-1:0] hits
);
  xk_kind_e kind;
  logic     data_mis, addr_mis, bcd_mis, digit_mis, sel_mis;
  logic     key_is_seven;

  always_comb begin
    kind         = xk_kind_e'(chk_kind);
    key_is_seven = (chk_key == 3'd7);
    data_mis  = chk_valid && (kind == KIND_DATA) && (chk_key != par_key(chk_word));
    addr_mis  = chk_valid && (kind == KIND_ADDR) &&
                (chk_key[1:0] != addr_res3(chk_word[ADDR_W-1:0]));
    bcd_mis   = chk_valid && (kind == KIND_BCD) &&
                (key_is_seven || (chk_key != bcd_res7(chk_word)));
    digit_mis = chk_valid && (kind == KIND_BCD) && bcd_bad(chk_word);
    sel_mis   = sel_valid && (req_addr != sel_addr);
  end

  always_comb begin
    hits            = '0;
    hits[FLG_PAR]   = data_mis;
    hits[FLG_AKEY]  = addr_mis;
    hits[FLG_BKEY]  = bcd_mis;
    hits[FLG_DIGIT] = digit_mis;
    hits[FLG_SEL]   = sel_mis;
  end

  assert_zero_word_rejected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_kind == 2'd0 && chk_word == '0 && chk_key == 3'd0 |-> data_mis);
  assert_akey_three_rejected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_kind == 2'd1 && chk_key[1:0] == 2'd3 |-> addr_mis);
  assert_seven_rejected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_kind == 2'd2 && key_is_seven |-> bcd_mis);
  assert_kind_none_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_kind == 2'd3 |-> !(data_mis || addr_mis || bcd_mis || digit_mis));
  assert_one_key_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_mis, addr_mis, bcd_mis || digit_mis}));
endmodule

// File: rtl/xk_sticky.sv
module xk_sticky #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= 1'b0;
      else        q[g] <= (q[g] & ~clr) | set[g];
    end

    assert_flag_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      q[g] && !clr |=> q[g]);
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set[g] |=> q[g]);
    assert_clear_works_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !set[g] |=> !q[g]);
  end
endmodule

// File: rtl/xfer_key_unit.sv
module xfer_key_unit
  import xk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_err,
  input  logic              gen_valid,
  input  logic [DATA_W-1:0] gen_data,
  input  logic [ADDR_W-1:0] gen_addr,
  output logic              gen_out_valid,
  output logic [2:0]        gen_pkey,
  output logic [1:0]        gen_akey,
  output logic [2:0]        gen_bkey,
  output logic              gen_bcd_bad,
  input  logic              chk_valid,
  input  logic [1:0]        chk_kind,
  input  logic [DATA_W-1:0] chk_word,
  input  logic [2:0]        chk_key,
  input  logic              sel_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] sel_addr,
  output logic              chk_done,
  output logic              chk_fail,
  output logic              err_par,
  output logic              err_akey,
  output logic              err_bkey,
  output logic              err_digit,
  output logic              err_sel
);
  logic [NUM_FLAGS-1:0] hits;
  logic [NUM_FLAGS-1:0] flags;
  logic                 key_fail;

  xk_gen u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (gen_valid),
    .in_data   (gen_data),
    .in_addr   (gen_addr),
    .out_valid (gen_out_valid),
    .out_pkey  (gen_pkey),
    .out_akey  (gen_akey),
    .out_bkey  (gen_bkey),
    .out_bad   (gen_bcd_bad)
  );

  xk_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_valid (chk_valid),
    .chk_kind  (chk_kind),
    .chk_word  (chk_word),
    .chk_key   (chk_key),
    .sel_valid (sel_valid),
    .req_addr  (req_addr),
    .sel_addr  (sel_addr),
    .hits      (hits)
  );

  xk_sticky #(.N(NUM_FLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_err),
    .set   (hits),
    .q     (flags)
  );

  assign key_fail = |hits[NUM_KEYF-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_done <= 1'b0;
      chk_fail <= 1'b0;
    end else begin
      chk_done <= chk_valid;
      chk_fail <= chk_valid && key_fail;
    end
  end

  assign err_par   = flags[FLG_PAR];
  assign err_akey  = flags[FLG_AKEY];
  assign err_bkey  = flags[FLG_BKEY];
  assign err_digit = flags[FLG_DIGIT];
  assign err_sel   = flags[FLG_SEL];

  assert_done_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> chk_done);
  assert_fail_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fail |-> (err_par || err_akey || err_bkey || err_digit) && chk_done);
  assert_sel_mismatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid && (req_addr != sel_addr) |=> err_sel);
  always_comb begin
    if (!rst_n)
      assert_reset_quiet_R11: assert (!chk_done && !chk_fail && flags == '0 && !gen_out_valid);
  end
endmodule

// File: tb/tb_xfer_key_unit.sv
`timescale 1ns/1ps
module tb_xfer_key_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_err = 1'b0;
  logic        gen_valid = 1'b0;
  logic [23:0] gen_data = '0;
  logic [14:0] gen_addr = '0;
  logic        gen_out_valid;
  logic [2:0]  gen_pkey;
  logic [1:0]  gen_akey;
  logic [2:0]  gen_bkey;
  logic        gen_bcd_bad;
  logic        chk_valid = 1'b0;
  logic [1:0]  chk_kind = '0;
  logic [23:0] chk_word = '0;
  logic [2:0]  chk_key = '0;
  logic        sel_valid = 1'b0;
  logic [14:0] req_addr = '0;
  logic [14:0] sel_addr = '0;
  logic        chk_done, chk_fail;
  logic        err_par, err_akey, err_bkey, err_digit, err_sel;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  xfer_key_unit dut (.*);

  // ---------------- reference model ----------------
  function automatic logic odd_bit(input logic [31:0] v);
    return ($countones(v) % 2) == 0;
  endfunction
  function automatic logic [2:0] m_par(input logic [23:0] w);
    return {odd_bit({8'd0, w}), odd_bit({20'd0, w[23:12]}), odd_bit({20'd0, w[11:0]})};
  endfunction
  function automatic int m_dec(input logic [23:0] w);
    int v = 0;
    for (int d = 5; d >= 0; d--) v = v * 10 + int'(w[d*4 +: 4]);
    return v;
  endfunction
  function automatic logic m_badd(input logic [23:0] w);
    for (int d = 0; d < 6; d++) if (w[d*4 +: 4] > 4'd9) return 1'b1;
    return 1'b0;
  endfunction

  logic       e_gv, e_bad, e_done, e_fail;
  logic [2:0] e_pkey, e_bkey;
  logic [1:0] e_akey;
  logic [4:0] e_flag;

  always @(posedge clk or negedge rst_n) begin
    logic [4:0] h;
    if (!rst_n) begin
      e_gv <= 0; e_pkey <= 0; e_akey <= 0; e_bkey <= 0; e_bad <= 0;
      e_done <= 0; e_fail <= 0; e_flag <= 0;
    end else begin
      e_gv <= gen_valid;
      if (gen_valid) begin
        e_pkey <= m_par(gen_data);
        e_akey <= 2'(int'(gen_addr) % 3);
        e_bkey <= 3'(m_dec(gen_data) % 7);
        e_bad  <= m_badd(gen_data);
      end
      h = '0;
      if (chk_valid) begin
        case (chk_kind)
          2'd0: h[0] = (chk_key != m_par(chk_word));
          2'd1: h[1] = (int'(chk_key[1:0]) != int'(chk_word[14:0]) % 3);
          2'd2: begin
            h[2] = (int'(chk_key) != m_dec(chk_word) % 7);
            h[3] = m_badd(chk_word);
          end
          default: ;
        endcase
      end
      h[4] = sel_valid && (req_addr != sel_addr);
      e_done <= chk_valid;
      e_fail <= chk_valid && (h[3:0] != 0);
      e_flag <= (clr_err ? 5'd0 : e_flag) | h;
    end
  end

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    cmp("R1", "gen_out_valid", 32'(gen_out_valid), 32'(e_gv));
    cmp("R1", "gen_pkey", 32'(gen_pkey), 32'(e_pkey));
    cmp("R2", "gen_akey", 32'(gen_akey), 32'(e_akey));
    cmp("R3", "gen_bkey", 32'(gen_bkey), 32'(e_bkey));
    cmp("R3", "gen_bcd_bad", 32'(gen_bcd_bad), 32'(e_bad));
    cmp("R4", "err_par", 32'(err_par), 32'(e_flag[0]));
    cmp("R5", "err_akey", 32'(err_akey), 32'(e_flag[1]));
    cmp("R6", "err_bkey", 32'(err_bkey), 32'(e_flag[2]));
    cmp("R6", "err_digit", 32'(err_digit), 32'(e_flag[3]));
    cmp("R8", "err_sel", 32'(err_sel), 32'(e_flag[4]));
    cmp("R9", "chk_done", 32'(chk_done), 32'(e_done));
    cmp("R9", "chk_fail", 32'(chk_fail), 32'(e_fail));
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle();
    gen_valid = 0; chk_valid = 0; sel_valid = 0; clr_err = 0;
  endtask
  task automatic tick();
    @(negedge clk);
  endtask
  task automatic put_chk(input logic [1:0] k, input logic [23:0] w, input logic [2:0] key);
    chk_valid = 1; chk_kind = k; chk_word = w; chk_key = key;
  endtask
  task automatic clear_all();
    idle(); clr_err = 1; tick(); clr_err = 0;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: all outputs zero while in reset
    cmp("R11", "outputs in reset",
        32'({gen_out_valid, gen_pkey, gen_akey, gen_bkey, gen_bcd_bad, chk_done, chk_fail,
             err_par, err_akey, err_bkey, err_digit, err_sel}), 32'd0);
    rst_n = 1; cmp_on = 1;
    tick();

    // R1/R2/R3 directed generator words
    gen_valid = 1; gen_data = 24'h000000; gen_addr = 15'h7FFF; tick();
    gen_data = 24'hFFFFFF; gen_addr = 15'd0; tick();
    gen_data = 24'h000001; gen_addr = 15'd5; tick();
    gen_data = 24'h999999; tick();
    gen_data = 24'h123456; tick();
    gen_data = 24'h12A456; tick();
    idle(); gen_data = 24'h555555; tick(); tick();  // R1 keys hold
    cmp("R1", "hold pkey", 32'(gen_pkey), 32'(m_par(24'h12A456)));
    cmp("R3", "bkey 123456 with A", 32'(gen_bkey), 32'(m_dec(24'h12A456) % 7));

    // R4: zero word with zero key is an error
    put_chk(2'd0, 24'h0, 3'd0); tick(); idle(); tick();
    cmp("R4", "zero word flagged", 32'(err_par), 32'd1);
    clear_all(); tick();
    // R5: key 3 always wrong, upper word bits ignored
    put_chk(2'd1, 24'hFF8003, 3'b100); tick();
    put_chk(2'd1, 24'h000000, 3'd3); tick(); idle(); tick();
    cmp("R5", "akey 3 flagged", 32'(err_akey), 32'd1);
    clear_all();
    // R6: key 7 and bad digit
    put_chk(2'd2, 24'h999999, 3'd7); tick();
    put_chk(2'd2, 24'h00000F, 3'(m_dec(24'h00000F) % 7)); tick(); idle(); tick();
    cmp("R6", "key 7 flagged", 32'(err_bkey), 32'd1);
    cmp("R6", "bad digit flagged", 32'(err_digit), 32'd1);
    clear_all(); tick();
    // R7: kind 3 never flags
    put_chk(2'd3, 24'h0, 3'd7); tick(); idle(); tick();
    cmp("R7", "kind none quiet", 32'({err_par, err_akey, err_bkey, err_digit, chk_fail}), 32'd0);
    // R8: selected-address mismatch
    sel_valid = 1; req_addr = 15'h1234; sel_addr = 15'h1234; tick();
    sel_addr = 15'h1235; tick(); idle(); tick(); tick();
    cmp("R8", "sel mismatch sticky", 32'(err_sel), 32'd1);
    // R10: clear coincident with new error keeps the flag
    clr_err = 1; put_chk(2'd0, 24'h0, 3'd0); tick(); idle(); tick();
    cmp("R10", "set wins over clear", 32'(err_par), 32'd1);
    cmp("R10", "clear drops sel", 32'(err_sel), 32'd0);
    clear_all(); tick();

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      logic [23:0] w;
      logic [1:0]  k;
      logic [2:0]  key;
      w = 24'($urandom);
      k = 2'($urandom);
      if ($urandom % 4 == 0) w[3:0] = 4'($urandom % 16);
      else for (int d = 0; d < 6; d++) w[d*4 +: 4] = 4'($urandom % 10);
      case (k)
        2'd0: key = m_par(w);
        2'd1: key = {1'($urandom), 2'(int'(w[14:0]) % 3)};
        2'd2: key = 3'(m_dec(w) % 7);
        default: key = 3'($urandom);
      endcase
      if ($urandom % 3 == 0) key = key ^ 3'(1 + $urandom % 7);
      gen_valid = 1'($urandom); gen_data = 24'($urandom); gen_addr = 15'($urandom);
      chk_valid = ($urandom % 4 != 0); chk_kind = k; chk_word = w; chk_key = key;
      sel_valid = 1'($urandom); req_addr = 15'($urandom);
      sel_addr = ($urandom % 8 == 0) ? 15'($urandom) : req_addr;
      clr_err = ($urandom % 16 == 0);
      tick();
    end
    idle(); tick(); tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule